// File: doc/BRIEF.md
# I/O Processor Fault Status Unit

This unit sits beside the memory-read and subchannel-read paths of an I/O processor. It watches each access for parity trouble and for memory interface errors. Each fault it detects is recorded as a sticky flag in a 32-bit status word. The unit also decides what happens to the I/O operation in progress: it stops at once with an unusual-end indication, it halts the device, or it carries on.

The outcome depends on the phase of the access. A fault during a command doubleword fetch always ends the operation with unusual end. A fault during a data transfer halts the device only when the active command has its halt-on-transmission-error flag set; otherwise the operation continues. The upper 19 bits of the status word hold the high-order bits of the address of the command doubleword now being processed. That field is captured each time a command fetch begins.

Top module: `iop_fault_status`

## Requirements
- R1: When `mrd_valid` is 1 and `mem_perr` differs from `iop_perr`, status bit 1 (bus check) is 1 from the following cycle.
- R2: A bus check or memory interface error with `cmd_phase`=0 gives a one-cycle `halt_req` pulse in the following cycle if `hte_flag` is 1, and no pulse if `hte_flag` is 0; `uend_req` stays 0 for that event.
- R3: A bus check or memory interface error with `cmd_phase`=1 gives a one-cycle `uend_req` pulse in the following cycle and no `halt_req`, whatever `hte_flag` is.
- R4: When `srd_valid` and `sub_perr` are both 1, status bit 2 (control check) is 1 and `uend_req` pulses in the following cycle.
- R5: `mie_stb`=1 sets status bit 3 (memory interface error) in the following cycle and follows the halt and terminate rules of R2 and R3.
- R6: `pfi` becomes 1 in the cycle after any bus check, control check, memory interface error, or `cm_fault` pulse; `cm_fault` sets no status bit.
- R7: Status bits 31..13 equal `cmd_addr[ADDR_W-1:ADDR_W-19]` as captured on the last cycle with `fetch_start`=1, and they hold between captures.
- R8: Status bit 0 and bits 12..4 always read 0.
- R9: Status fault bits and `pfi` stay set until reset or a cycle with `clr`=1. A fault arriving in the same cycle as `clr` still leaves its bit set.
- R10: When several faults occur in one cycle, every matching bit is set. If any of them calls for unusual end, `halt_req` is suppressed.
- R11: After reset, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of fault flags and pfi |
| mrd_valid | input | 1 | Main memory read cycle in progress |
| mem_perr | input | 1 | Parity error status reported by memory |
| iop_perr | input | 1 | Parity error status seen by the processor |
| cmd_phase | input | 1 | 1 = command doubleword fetch, 0 = data access |
| hte_flag | input | 1 | Halt-on-transmission-error flag of the active command |
| srd_valid | input | 1 | Subchannel read in progress |
| sub_perr | input | 1 | Parity error on the subchannel read |
| mie_stb | input | 1 | Memory interface error strobe |
| cm_fault | input | 1 | Control memory fault strobe |
| fetch_start | input | 1 | A command fetch begins; capture cmd_addr |
| cmd_addr | input | ADDR_W | Address of the command doubleword |
| status | output | 32 | Fault status word |
| pfi | output | 1 | Processor fault indicator |
| halt_req | output | 1 | Device halt request pulse |
| uend_req | output | 1 | Unusual-end terminate pulse |

## Verification
The bench sets ADDR_W to 24 rather than the default 22. The address field is then taken five bits up from bit 0. Any slice that assumes the default offset shows up as a mismatch in bits 31..13. Random streams mix sparse faults across both access phases and both flag values, so same-cycle collisions between halt and terminate causes occur often. Directed steps add clear-versus-fault races and the bare control memory fault.

// File: rtl/iop_fault_status.sv
module iop_fault_status #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mrd_valid,
  input  logic              mem_perr,
  input  logic              iop_perr,
  input  logic              cmd_phase,
  input  logic              hte_flag,
  input  logic              srd_valid,
  input  logic              sub_perr,
  input  logic              mie_stb,
  input  logic              cm_fault,
  input  logic              fetch_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [31:0]       status,
  output logic              pfi,
  output logic              halt_req,
  output logic              uend_req
);
  localparam int FLD_W   = 19;
  localparam int FLD_LSB = ADDR_W - FLD_W;

  logic bcf_q, ccf_q, mie_q, pfi_q, halt_q, uend_q;
  logic [FLD_W-1:0] addr_q;

  logic bcf_ev, ccf_ev, mem_ev, term_ev, halt_ev;
  assign bcf_ev  = mrd_valid & (mem_perr ^ iop_perr);
  assign ccf_ev  = srd_valid & sub_perr;
  assign mem_ev  = bcf_ev | mie_stb;
  assign term_ev = ccf_ev | (mem_ev & cmd_phase);
  assign halt_ev = mem_ev & ~cmd_phase & hte_flag & ~term_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcf_q  <= 1'b0;
      ccf_q  <= 1'b0;
      mie_q  <= 1'b0;
      pfi_q  <= 1'b0;
      halt_q <= 1'b0;
      uend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      bcf_q  <= (bcf_q & ~clr) | bcf_ev;
      ccf_q  <= (ccf_q & ~clr) | ccf_ev;
      mie_q  <= (mie_q & ~clr) | mie_stb;
      pfi_q  <= (pfi_q & ~clr) | bcf_ev | ccf_ev | mie_stb | cm_fault;
      halt_q <= halt_ev;
      uend_q <= term_ev;
      if (fetch_start) addr_q <= cmd_addr[ADDR_W-1:FLD_LSB];
    end
  end

  assign status   = {addr_q, 9'b0, mie_q, ccf_q, bcf_q, 1'b0};
  assign pfi      = pfi_q;
  assign halt_req = halt_q;
  assign uend_req = uend_q;

  assert_bcf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && (mem_perr != iop_perr)) |=> status[1]);

  assert_fetch_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && (mem_perr != iop_perr) && cmd_phase) |=> (uend_req && !halt_req));

  assert_ccf_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (srd_valid && sub_perr) |=> (status[2] && uend_req));

  assert_mie_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mie_stb |=> (status[3] && pfi));

  assert_pfi_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:1] != 3'b000) |-> pfi);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr) |=> status[1]);

  assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && uend_req));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_start |=> $stable(status[31:13]));
endmodule

// File: tb/iop_fault_status_tb.sv
`timescale 1ns/1ps
module iop_fault_status_tb_top;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic clr = 0, mrd_valid = 0, mem_perr = 0, iop_perr = 0, cmd_phase = 0, hte_flag = 0;
  logic srd_valid = 0, sub_perr = 0, mie_stb = 0, cm_fault = 0, fetch_start = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0] status;
  logic pfi, halt_req, uend_req;

  int total = 0, bad = 0;
  bit finished = 0;

  logic m_bcf = 0, m_ccf = 0, m_mie = 0, m_pfi = 0, m_halt = 0, m_uend = 0;
  logic [18:0] m_addr = '0;

  always #4 clk = ~clk;

  iop_fault_status #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mrd_valid(mrd_valid), .mem_perr(mem_perr),
    .iop_perr(iop_perr), .cmd_phase(cmd_phase), .hte_flag(hte_flag), .srd_valid(srd_valid),
    .sub_perr(sub_perr), .mie_stb(mie_stb), .cm_fault(cm_fault), .fetch_start(fetch_start),
    .cmd_addr(cmd_addr), .status(status), .pfi(pfi), .halt_req(halt_req), .uend_req(uend_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {m_addr, 9'b0, m_mie, m_ccf, m_bcf, 1'b0};
  endfunction

  task automatic compare_all();
    chk("R1 bcf bit", 32'(status[1]), 32'(m_bcf));
    chk("R4 ccf bit", 32'(status[2]), 32'(m_ccf));
    chk("R5 mie bit", 32'(status[3]), 32'(m_mie));
    chk("R6 pfi", 32'(pfi), 32'(m_pfi));
    chk("R7 addr field", 32'(status[31:13]), 32'(m_addr));
    chk("R8 reserved", 32'({status[12:4], status[0]}), 32'd0);
    chk("R2 halt_req", 32'(halt_req), 32'(m_halt));
    chk("R3 uend_req", 32'(uend_req), 32'(m_uend));
  endtask

  task automatic model_update();
    logic bcf, ccf, mem, term;
    bcf  = mrd_valid & (mem_perr ^ iop_perr);
    ccf  = srd_valid & sub_perr;
    mem  = bcf | mie_stb;
    term = ccf | (mem & cmd_phase);
    m_halt = mem & !cmd_phase & hte_flag & !term;
    m_uend = term;
    m_bcf = (m_bcf & !clr) | bcf;
    m_ccf = (m_ccf & !clr) | ccf;
    m_mie = (m_mie & !clr) | mie_stb;
    m_pfi = (m_pfi & !clr) | bcf | ccf | mie_stb | cm_fault;
    if (fetch_start) m_addr = cmd_addr[AW-1:AW-19];
  endtask

  task automatic idle_inputs();
    clr = 0; mrd_valid = 0; mem_perr = 0; iop_perr = 0; cmd_phase = 0; hte_flag = 0;
    srd_valid = 0; sub_perr = 0; mie_stb = 0; cm_fault = 0; fetch_start = 0;
  endtask

  task automatic step();
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset status", status, 32'd0);
    chk("R11 reset flags", {29'd0, pfi, halt_req, uend_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    idle_inputs(); fetch_start = 1; cmd_addr = 24'hABCDEF; step();
    idle_inputs(); mrd_valid = 1; mem_perr = 1; hte_flag = 1; step();
    chk("R2 data halt pulse", 32'(halt_req), 32'd1);
    idle_inputs(); step();
    chk("R9 halt single cycle", 32'(halt_req), 32'd0);
    idle_inputs(); mrd_valid = 1; iop_perr = 1; cmd_phase = 1; hte_flag = 1; step();
    chk("R3 fetch terminate", {halt_req, uend_req}, 32'b01);
    idle_inputs(); mrd_valid = 1; mem_perr = 1; step();
    chk("R2 no halt without flag", 32'(halt_req), 32'd0);
    idle_inputs(); clr = 1; step();
    chk("R9 clear", {status[3:1], 28'd0, pfi}, 32'd0);
    idle_inputs(); mrd_valid = 1; mem_perr = 1; hte_flag = 1; srd_valid = 1; sub_perr = 1;
    mie_stb = 1; step();
    chk("R10 all bits and uend wins", {status[3:1], 27'd0, halt_req, uend_req}, {3'b111, 29'b01});
    idle_inputs(); clr = 1; mie_stb = 1; step();
    chk("R9 fault beats clear", {status[3:1], 28'd0, pfi}, {3'b100, 29'd1});
    idle_inputs(); clr = 1; step();
    idle_inputs(); cm_fault = 1; step();
    chk("R6 control memory fault", {status[3:1], 28'd0, pfi}, 32'd1);
    idle_inputs(); mie_stb = 1; hte_flag = 1; step();
    chk("R5 mie data halt", {halt_req, uend_req}, 32'b10);

    for (int i = 0; i < 3000; i++) begin
      idle_inputs();
      clr         = ($urandom_range(0, 15) == 0);
      mrd_valid   = $urandom_range(0, 1);
      mem_perr    = ($urandom_range(0, 7) == 0);
      iop_perr    = ($urandom_range(0, 7) == 0);
      cmd_phase   = $urandom_range(0, 1);
      hte_flag    = $urandom_range(0, 1);
      srd_valid   = $urandom_range(0, 1);
      sub_perr    = ($urandom_range(0, 11) == 0);
      mie_stb     = ($urandom_range(0, 15) == 0);
      cm_fault    = ($urandom_range(0, 19) == 0);
      fetch_start = ($urandom_range(0, 5) == 0);
      cmd_addr    = AW'($urandom);
      step();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule